// File: doc/BRIEF.md
# Programmable Address Decode Window Unit

This block sits in front of a bus master and decides where each of its accesses goes. It holds eight software-programmed windows. Each window has a base, a size, a target identifier, an attribute byte and an enable. Both base and size work in 64 KB units. A request address is compared against all enabled windows in parallel. One clock later the unit returns a hit or a decode error, the index of the winning window, that window's target and attribute, and the address to present on the destination bus.

Software programs the windows through a plain 32-bit register port. Each window owns a four-word slot holding a control word, a base word, a remap-low word and a remap-high word. Only the lowest-numbered windows, a parameterised count, can move the upper half of the address to a different bus location. The remaining windows pass the address through unchanged.

Top module: `addr_window_unit`

## Requirements
- R1: After reset every window is disabled, every register reads zero and every lookup misses.
- R2: Window w occupies register bytes w*16 to w*16+15. The word select is reg_addr[3:2], with 0 = control, 1 = base, 2 = remap low and 3 = remap high. Control reads back size-minus-one in bits 31:16, attribute in bits 15:8, target in bits 7:4 and enable in bit 0, with bits 3:1 reading zero.
- R3: Base and remap-low keep only bits 31:16 of a write, and their bits 15:0 read zero.
- R4: A write to a slot whose index (reg_addr[7:4]) is 8 or higher changes no window, and a read of such a slot returns zero.
- R5: An enabled window matches an address when address bits 31:16, XORed with the base and then masked by the inverse of the size field, are all zero.
- R6: A window with its enable bit clear, including one whose control word is zero, never matches.
- R7: When several windows match, the lowest-numbered one supplies the window index, target, attribute and translated address.
- R8: A miss reports rsp_err=1 and rsp_hit=0, with window index, target and attribute all zero, and the address passed through unchanged.
- R9: For a window below NUM_REMAP, the output address takes bits 31:16 from its remap-low register and keeps request bits 15:0.
- R10: Windows at or above NUM_REMAP translate one-to-one. Their remap-low slot ignores writes and reads zero.
- R11: The remap-high word of every window reads zero and ignores writes.
- R12: Every request with req_valid high yields exactly one response, with rsp_valid high on the next clock. Back-to-back requests are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Lookup request address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Some window matched |
| rsp_err | output | 1 | Decode error: no window matched |
| rsp_win | output | WIN_W | Index of the winning window |
| rsp_target | output | 4 | Target identifier of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The hardest situation to reach is one where priority, remapping and enable all interact. That happens when an address lies in two overlapping windows, one of them able to remap and the other not, and the winner is later disabled so that the lower-priority window takes over. The stimulus builds exactly that layout: a large remapping window over a small one-to-one window. It checks the remapped result, clears the large window's control word, and repeats the same address. It also aims addresses at the last and first 64 KB boundaries of a window, and writes to the out-of-range slot that would alias window 0 if the index were truncated.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned TGT_W  = 4;
  localparam int unsigned ATTR_W = 8;

  typedef enum logic [1:0] {
    SLOT_CTRL     = 2'd0,
    SLOT_BASE     = 2'd1,
    SLOT_REMAP_LO = 2'd2,
    SLOT_REMAP_HI = 2'd3
  } slot_e;

  typedef struct packed {
    logic [HALF_W-1:0] size_hi;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  target;
    logic              en;
    logic [HALF_W-1:0] base_hi;
  } win_cfg_t;

  // Upper-half compare with a 64 KB granular size mask.
  function automatic logic win_hits(input logic [ADDR_W-1:0] addr, input win_cfg_t c);
    logic [HALF_W-1:0] diff;
    diff = (addr[ADDR_W-1:HALF_W] ^ c.base_hi) & ~c.size_hi;
    return c.en && (diff == '0);
  endfunction

  // Replace the upper half, keep the 64 KB offset.
  function automatic logic [ADDR_W-1:0] xlat(input logic [ADDR_W-1:0] addr,
                                             input logic [HALF_W-1:0] new_hi);
    return {new_hi, addr[HALF_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] ctrl_word(input win_cfg_t c);
    return {c.size_hi, c.attr, c.target, 3'b000, c.en};
  endfunction
endpackage

// File: rtl/awu_regs.sv
module awu_regs
  import awu_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int REG_AW    = 8,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int SLOT_W   = REG_AW - 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [ADDR_W-1:0]   reg_wdata,
  output logic [ADDR_W-1:0]   reg_rdata,
  output win_cfg_t            cfg_o   [NUM_WIN],
  output logic [HALF_W-1:0]   remap_o [NUM_WIN],
  output logic [NUM_WIN-1:0]  en_vec_o
);
  logic [SLOT_W-1:0] slot_idx;
  logic              slot_ok;
  slot_e             kind;
  logic [WIN_W-1:0]  rd_win;
  logic              unused_addr_bits;
  logic              unused_wdata_bits;

  assign slot_idx = reg_addr[REG_AW-1:4];
  assign slot_ok  = int'(slot_idx) < NUM_WIN;
  assign kind     = slot_e'(reg_addr[3:2]);
  assign rd_win   = slot_idx[WIN_W-1:0];
  assign unused_addr_bits  = ^reg_addr[1:0];
  assign unused_wdata_bits = ^reg_wdata[3:1];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic     wr_sel;
    win_cfg_t cfg_q;

    assign wr_sel = reg_we && slot_ok && (int'(slot_idx) == w);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (wr_sel) begin
        if (kind == SLOT_CTRL) begin
          cfg_q.size_hi <= reg_wdata[31:16];
          cfg_q.attr    <= reg_wdata[15:8];
          cfg_q.target  <= reg_wdata[7:4];
          cfg_q.en      <= reg_wdata[0];
        end else if (kind == SLOT_BASE) begin
          cfg_q.base_hi <= reg_wdata[31:16];
        end
      end
    end

    assign cfg_o[w]    = cfg_q;
    assign en_vec_o[w] = cfg_q.en;

    if (w < NUM_REMAP) begin : g_remap
      logic [HALF_W-1:0] remap_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          remap_q <= '0;
        else if (wr_sel && kind == SLOT_REMAP_LO)
          remap_q <= reg_wdata[31:16];
      end
      assign remap_o[w] = remap_q;
    end else begin : g_flat
      assign remap_o[w] = '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (slot_ok) begin
      unique case (kind)
        SLOT_CTRL:     reg_rdata = ctrl_word(cfg_o[rd_win]);
        SLOT_BASE:     reg_rdata = {cfg_o[rd_win].base_hi, 16'h0000};
        SLOT_REMAP_LO: reg_rdata = {remap_o[rd_win], 16'h0000};
        SLOT_REMAP_HI: reg_rdata = '0;
        default:       reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/awu_match.sv
module awu_match
  import awu_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [ADDR_W-1:0]  req_addr,
  input  win_cfg_t           cfg_i [NUM_WIN],
  output logic [NUM_WIN-1:0] match_vec
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign match_vec[w] = win_hits(req_addr, cfg_i[w]);
  end
endmodule

// File: rtl/awu_select.sv
module awu_select
  import awu_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_WIN-1:0] match_vec,
  input  win_cfg_t           cfg_i   [NUM_WIN],
  input  logic [HALF_W-1:0]  remap_i [NUM_WIN],
  output logic [NUM_WIN-1:0] grant_vec,
  output logic               hit,
  output logic [WIN_W-1:0]   win_idx,
  output logic [TGT_W-1:0]   target,
  output logic [ATTR_W-1:0]  attr,
  output logic [ADDR_W-1:0]  out_addr
);
  // Scan from the top so the lowest matching index is written last.
  always_comb begin
    grant_vec = '0;
    hit       = 1'b0;
    win_idx   = '0;
    target    = '0;
    attr      = '0;
    out_addr  = req_addr;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (match_vec[w]) begin
        grant_vec    = '0;
        grant_vec[w] = 1'b1;
        hit          = 1'b1;
        win_idx      = WIN_W'(w);
        target       = cfg_i[w].target;
        attr         = cfg_i[w].attr;
        out_addr     = (w < NUM_REMAP) ? xlat(req_addr, remap_i[w]) : req_addr;
      end
    end
  end
endmodule

// File: rtl/addr_window_unit.sv
module addr_window_unit
  import awu_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 2,
  parameter int REG_AW    = 8,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [WIN_W-1:0]  rsp_win,
  output logic [3:0]        rsp_target,
  output logic [7:0]        rsp_attr,
  output logic [31:0]       rsp_addr
);
  win_cfg_t            cfg     [NUM_WIN];
  logic [HALF_W-1:0]   remap   [NUM_WIN];
  logic [NUM_WIN-1:0]  en_vec;
  logic [NUM_WIN-1:0]  match_vec;
  logic [NUM_WIN-1:0]  grant_vec;
  logic                sel_hit;
  logic [WIN_W-1:0]    sel_win;
  logic [TGT_W-1:0]    sel_target;
  logic [ATTR_W-1:0]   sel_attr;
  logic [ADDR_W-1:0]   sel_addr;

  awu_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cfg_o     (cfg),
    .remap_o   (remap),
    .en_vec_o  (en_vec)
  );

  awu_match #(.NUM_WIN(NUM_WIN)) u_match (
    .req_addr  (req_addr),
    .cfg_i     (cfg),
    .match_vec (match_vec)
  );

  awu_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_select (
    .req_addr  (req_addr),
    .match_vec (match_vec),
    .cfg_i     (cfg),
    .remap_i   (remap),
    .grant_vec (grant_vec),
    .hit       (sel_hit),
    .win_idx   (sel_win),
    .target    (sel_target),
    .attr      (sel_attr),
    .out_addr  (sel_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & sel_hit;
      rsp_err   <= req_valid & ~sel_hit;
      if (req_valid) begin
        rsp_win    <= sel_win;
        rsp_target <= sel_target;
        rsp_attr   <= sel_attr;
        rsp_addr   <= sel_addr;
      end
    end
  end
endmodule

// File: rtl/awu_checker.sv
module awu_checker #(
  parameter int NUM_WIN = 8,
  parameter int REG_AW  = 8,
  parameter int WIN_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_err,
  input logic [WIN_W-1:0]   rsp_win,
  input logic [3:0]         rsp_target,
  input logic [7:0]         rsp_attr,
  input logic [31:0]        rsp_addr,
  input logic [NUM_WIN-1:0] match_vec,
  input logic [NUM_WIN-1:0] grant_vec,
  input logic [NUM_WIN-1:0] en_vec,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [31:0]        reg_rdata
);
  assert_req_to_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_no_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_quiet_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_err));
  assert_hit_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_err));
  assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && match_vec == '0) |=>
      (rsp_err && rsp_win == '0 && rsp_target == '0 && rsp_attr == '0 &&
       rsp_addr == $past(req_addr)));
  assert_offset_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[15:0] == $past(req_addr[15:0]));
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~match_vec) == '0));
  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec != '0) |-> (((grant_vec - NUM_WIN'(1)) & match_vec) == '0));
  assert_disabled_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_vec & ~en_vec) == '0);
  assert_remap_hi_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:2] == 2'b11) |-> reg_rdata == '0);
endmodule

bind addr_window_unit awu_checker #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW), .WIN_W(WIN_W)) u_awu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_err    (rsp_err),
  .rsp_win    (rsp_win),
  .rsp_target (rsp_target),
  .rsp_attr   (rsp_attr),
  .rsp_addr   (rsp_addr),
  .match_vec  (match_vec),
  .grant_vec  (grant_vec),
  .en_vec     (en_vec),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/test_addr_window_unit.sv
module test_addr_window_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int NREMAP = 2;

  typedef struct packed {
    logic        hit;
    logic        err;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t  exp_q[$];
  string tag_q[$];

  // Bench's own view of the programmed windows.
  logic        m_en    [NWIN];
  logic [15:0] m_size  [NWIN];
  logic [15:0] m_base  [NWIN];
  logic [15:0] m_remap [NWIN];
  logic [3:0]  m_tgt   [NWIN];
  logic [7:0]  m_attr  [NWIN];

  addr_window_unit i_addr_window_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .rsp_win(rsp_win), .rsp_target(rsp_target),
    .rsp_attr(rsp_attr), .rsp_addr(rsp_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic exp_t predict(input logic [31:0] a);
    exp_t e;
    e = '{hit: 1'b0, err: 1'b1, win: 3'd0, tgt: 4'd0, attr: 8'd0, addr: a};
    for (int w = 0; w < NWIN; w++) begin
      if (!e.hit && m_en[w] && ((a[31:16] & ~m_size[w]) == (m_base[w] & ~m_size[w]))) begin
        e.hit = 1'b1; e.err = 1'b0; e.win = 3'(w);
        e.tgt = m_tgt[w]; e.attr = m_attr[w];
        e.addr = (w < NREMAP) ? {m_remap[w], a[15:0]} : a;
      end
    end
    return e;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int idx;
    idx = int'(a[7:4]);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (idx < NWIN) begin
      case (a[3:2])
        2'd0: begin m_size[idx] = d[31:16]; m_attr[idx] = d[15:8];
                    m_tgt[idx] = d[7:4]; m_en[idx] = d[0]; end
        2'd1: m_base[idx] = d[31:16];
        2'd2: if (idx < NREMAP) m_remap[idx] = d[31:16];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] expv, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== expv) begin
      fails++;
      $display("FAIL %s: read 0x%02h actual 0x%08h expected 0x%08h", tag, a, reg_rdata, expv);
    end
  endtask

  // Driver: each call occupies one cycle, so consecutive calls run back to back.
  task automatic lookup(input logic [31:0] a, input string tag);
    req_valid = 1'b1;
    req_addr  = a;
    exp_q.push_back(predict(a));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R12: response without request, actual rsp_valid=1 expected 0");
      end else begin
        exp_t  e;
        exp_t  act;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = '{hit: rsp_hit, err: rsp_err, win: rsp_win, tgt: rsp_target,
                attr: rsp_attr, addr: rsp_addr};
        if (act !== e) begin
          fails++;
          $display("FAIL %s: actual hit=%0b err=%0b win=%0d tgt=%0h attr=%02h addr=%08h expected hit=%0b err=%0b win=%0d tgt=%0h attr=%02h addr=%08h",
                   t, act.hit, act.err, act.win, act.tgt, act.attr, act.addr,
                   e.hit, e.err, e.win, e.tgt, e.attr, e.addr);
        end
      end
    end
  end

  initial begin
    for (int w = 0; w < NWIN; w++) begin
      m_en[w] = 0; m_size[w] = '0; m_base[w] = '0;
      m_remap[w] = '0; m_tgt[w] = '0; m_attr[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h00, 32'h0, "R1");
    rd(8'h74, 32'h0, "R1");
    lookup(32'h1000_0000, "R1");
    @(negedge clk);

    // R2 / R3 / R11: window 0 layout
    wr(8'h00, 32'h000F_514F);
    rd(8'h00, 32'h000F_5141, "R2");
    wr(8'h04, 32'h1000_ABCD);
    rd(8'h04, 32'h1000_0000, "R3");
    wr(8'h08, 32'h0040_1234);
    rd(8'h08, 32'h0040_0000, "R3");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R11");

    // window 1: large remapping window over window 2
    wr(8'h14, 32'h2000_0000);
    wr(8'h18, 32'h8000_0000);
    wr(8'h10, 32'h0FFF_5931);
    // window 2: 64 KB, no remap
    wr(8'h24, 32'h2000_0000);
    wr(8'h20, 32'h0000_1E11);
    // window 3: no remap; remap slot must ignore writes (R10)
    wr(8'h34, 32'h3000_0000);
    wr(8'h30, 32'h00FF_1D11);
    wr(8'h38, 32'hDEAD_0000);
    rd(8'h38, 32'h0, "R10");
    // window 4 programmed but enable clear, window 5 control zero (R6)
    wr(8'h44, 32'h4000_0000);
    wr(8'h40, 32'h00FF_AA50);
    wr(8'h54, 32'h5000_0000);

    // R4: out-of-range slots
    wr(8'h80, 32'hFFFF_FF01);
    wr(8'h84, 32'h0000_0000);
    rd(8'h80, 32'h0, "R4");
    rd(8'hF4, 32'h0, "R4");
    rd(8'h00, 32'h000F_5141, "R4");
    rd(8'h04, 32'h1000_0000, "R4");

    // Back-to-back lookups (R12)
    lookup(32'h1000_1234, "R9");
    lookup(32'h100F_FFFF, "R5");
    lookup(32'h1010_0000, "R5");
    lookup(32'h0FFF_FFFF, "R5");
    lookup(32'h2000_1234, "R7");
    lookup(32'h2ABC_0001, "R9");
    lookup(32'h3012_3456, "R10");
    lookup(32'h4000_0010, "R6");
    lookup(32'h5000_0000, "R6");
    lookup(32'hFFFF_0000, "R8");
    @(negedge clk);

    // R7: remove the higher-priority window, the overlapped one takes over
    wr(8'h10, 32'h0000_0000);
    lookup(32'h2000_1234, "R7");
    lookup(32'h2001_0000, "R5");
    @(negedge clk);

    // R12: a single request then idle cycles
    lookup(32'h3000_0000, "R12");
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12: pending responses actual %0d expected 0", exp_q.size());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule